// File: doc/BRIEF.md
# Framed SPI Register Slave with Sticky Event Flags

This block is a serial register slave that accepts fixed-length SPI frames of 32 clocks (mode 0: the master changes MOSI while SCLK is low, and both sides sample on the rising SCLK edge). The block runs entirely in the system clock domain. It synchronizes SCLK, chip select and MOSI, counts rising SCLK edges in each chip-select window, and shifts in a frame. The frame is sent most significant bit first and is laid out as one direction bit (1 = read, 0 = write), then a 7-bit register address, then 24 data bits. A write is committed only at the chip-select release that ends a frame of exactly 32 clocks. A read returns the addressed register on MISO during the 24 data clocks.

Address 0 holds a status word. Its bits [2:0] are sticky event flags: bit 0 records a loss of digital lock, bit 1 records a band reselection (loss of analog lock), and bit 2 records a framing error. Each flag is set by a one-cycle event input, or by the internal frame check for bit 2. A flag stays set until a write of 1 to its bit clears it. Bits [7:3] of the status word are plain read/write control bits. Bits [15:8] return a fixed device code and bits [23:16] return a fixed revision code. Addresses 1 to NUM_CFG hold ordinary 24-bit configuration registers. All other addresses read as zero, and writes to them are dropped.

Top module: `spi_stat_regs`

## Requirements
- R1: A write frame (direction bit 0) of exactly 32 SCLK rising edges stores its 24 data bits into the configuration register at its address (1..NUM_CFG, exposed on cfg_regs[(a-1)*24 +: 24]) when chip select rises; configuration registers change at no other time.
- R2: A frame with fewer or more than 32 SCLK rising edges, whatever its direction bit, sets status bit 2 and updates no register; the edge counter saturates at 63 so very long frames are still caught.
- R3: A read frame (direction bit 1) of 32 clocks drives the addressed register on MISO, bit 23 first, for the 24 data clocks; MISO is valid before each rising SCLK edge of the data phase.
- R4: A read frame with a wrong clock count also sets status bit 2.
- R5: A one-cycle pulse on evt_dig_unlock sets status bit 0, which then stays 1.
- R6: A one-cycle pulse on evt_band_sel sets status bit 1, which then stays 1.
- R7: Writing address 0 clears each flag whose data bit [2:0] is 1 and leaves flags whose data bit is 0 unchanged.
- R8: An event pulse in the same cycle as the write that clears its flag leaves the flag at 1.
- R9: Status bits [15:8] always read 8'h5A and bits [23:16] always read 8'h02 (defaults); writes do not change them.
- R10: Status bits [7:3] (ctrl_bits) are read/write through address 0 and reset to zero.
- R11: After reset all flags, control bits and configuration registers are zero.
- R12: Writes to unmapped addresses change no register, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| evt_dig_unlock | input | 1 | One-cycle pulse on a digital lock loss |
| evt_band_sel | input | 1 | One-cycle pulse on a band reselection |
| sticky_flags | output | 3 | Current sticky flags {framing error, band, digital} |
| ctrl_bits | output | 5 | Control bits held in status bits [7:3] |
| cfg_regs | output | NUM_CFG*24 | Configuration registers, register 1 in the low bits |

## Verification
The properties assume that SCLK, chip select and MOSI change slowly compared with the system clock. Each level must hold for several system clocks, so that every SCLK edge and every chip-select edge is seen once after synchronization and no SCLK edge coincides with a chip-select edge. The stimulus meets this by holding each SCLK half period for six system clocks and by leaving idle clocks around every chip-select edge. Event inputs are driven as single-cycle pulses, and one pulse is placed on the exact commit cycle of a clearing write.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int FRAME_BITS = 32;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = FRAME_BITS - 1 - ADDR_W;
  localparam int CNT_W      = $clog2(FRAME_BITS) + 1;
  localparam int FLAG_W     = 3;
  localparam int CTRL_W     = 5;
  localparam int ID_W       = 8;

  localparam int FLG_DIG  = 0;
  localparam int FLG_BAND = 1;
  localparam int FLG_ERR  = 2;

  typedef struct packed {
    logic [ID_W-1:0]   rev;
    logic [ID_W-1:0]   dev;
    logic [CTRL_W-1:0] ctrl;
    logic [FLAG_W-1:0] flags;
  } status_t;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl  = sync_q;
  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_low,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_bit,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              miso_bit,
  output logic              frame_end,
  output logic              frame_ok,
  output frame_t            frame_q,
  output logic [CNT_W-1:0]  edge_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(1 + ADDR_W);

  logic [FRAME_BITS-1:0] shreg;
  logic [DATA_W-1:0]     tx_q;
  logic                  hdr_done;
  logic                  tx_shift;

  // the last header bit arrives on this edge: address is complete now
  assign hdr_done = cs_low & sclk_rise & (edge_cnt == CNT_HDR - 1'b1);
  assign rd_addr  = {shreg[ADDR_W-2:0], mosi_bit};
  assign tx_shift = cs_low & sclk_fall & (edge_cnt > CNT_HDR) & (edge_cnt < CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      shreg    <= '0;
    end else if (cs_fall) begin
      edge_cnt <= '0;
      shreg    <= '0;
    end else if (cs_low && sclk_rise) begin
      if (edge_cnt != CNT_MAX) edge_cnt <= edge_cnt + 1'b1;
      if (edge_cnt < CNT_FULL) shreg <= {shreg[FRAME_BITS-2:0], mosi_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (cs_fall || cs_rise) begin
      tx_q <= '0;
    end else if (hdr_done) begin
      tx_q <= shreg[ADDR_W-1] ? rd_data : '0;
    end else if (tx_shift) begin
      tx_q <= {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  assign miso_bit  = tx_q[DATA_W-1];
  assign frame_end = cs_rise;
  assign frame_ok  = (edge_cnt == CNT_FULL);
  assign frame_q   = frame_t'(shreg);
endmodule

// File: rtl/spi_stat_regfile.sv
module spi_stat_regfile
  import spi_stat_pkg::*;
#(
  parameter int NUM_CFG = 4,
  parameter logic [ID_W-1:0] REV_VAL = 8'h02,
  parameter logic [ID_W-1:0] DEV_VAL = 8'h5A
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [FLAG_W-1:0]         evt_flags,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic [FLAG_W-1:0]         flags_q,
  output logic [CTRL_W-1:0]         ctrl_q,
  output logic [NUM_CFG*DATA_W-1:0] cfg_flat
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = '0;

  status_t           wr_word;
  logic              stat_wr;
  logic [FLAG_W-1:0] clr_mask;
  logic [DATA_W-1:0] cfg_mem [NUM_CFG];

  assign wr_word  = status_t'(wr_data);
  assign stat_wr  = wr_en && (wr_addr == STAT_ADDR);
  assign clr_mask = {FLAG_W{stat_wr}} & wr_word.flags;

  // event has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= evt_flags | (flags_q & ~clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (stat_wr) ctrl_q <= wr_word.ctrl;
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_mem[g] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(g + 1))) cfg_mem[g] <= wr_data;
    end
    assign cfg_flat[g*DATA_W +: DATA_W] = cfg_mem[g];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == STAT_ADDR) rd_data = {REV_VAL, DEV_VAL, ctrl_q, flags_q};
    for (int i = 0; i < NUM_CFG; i++)
      if (rd_addr == ADDR_W'(i + 1)) rd_data = cfg_mem[i];
  end
endmodule

// File: rtl/spi_stat_regs.sv
module spi_stat_regs
  import spi_stat_pkg::*;
#(
  parameter int NUM_CFG = 4,
  parameter logic [7:0] REV_VAL = 8'h02,
  parameter logic [7:0] DEV_VAL = 8'h5A
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      spi_sclk,
  input  logic                      spi_cs_n,
  input  logic                      spi_mosi,
  output logic                      spi_miso,
  input  logic                      evt_dig_unlock,
  input  logic                      evt_band_sel,
  output logic [2:0]                sticky_flags,
  output logic [4:0]                ctrl_bits,
  output logic [NUM_CFG*24-1:0]     cfg_regs
);
  logic [2:0]        s_lvl, s_rise, s_fall;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              frame_end, frame_ok, wr_en;
  frame_t            frame_q;
  logic [CNT_W-1:0]  edge_cnt;
  logic [FLAG_W-1:0] evt_flags;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  spi_sync_edge #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({spi_cs_n, spi_sclk, spi_mosi}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  spi_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .cs_low(~s_lvl[2]), .cs_fall(s_fall[2]), .cs_rise(s_rise[2]),
    .sclk_rise(s_rise[1]), .sclk_fall(s_fall[1]), .mosi_bit(s_lvl[0]),
    .rd_data(rd_data), .rd_addr(rd_addr), .miso_bit(spi_miso),
    .frame_end(frame_end), .frame_ok(frame_ok), .frame_q(frame_q),
    .edge_cnt(edge_cnt)
  );

  assign wr_en   = frame_end & frame_ok & ~frame_q.rd;
  assign wr_addr = frame_q.addr;
  assign wr_data = frame_q.data;

  always_comb begin
    evt_flags           = '0;
    evt_flags[FLG_DIG]  = evt_dig_unlock;
    evt_flags[FLG_BAND] = evt_band_sel;
    evt_flags[FLG_ERR]  = frame_end & ~frame_ok;
  end

  spi_stat_regfile #(.NUM_CFG(NUM_CFG), .REV_VAL(REV_VAL), .DEV_VAL(DEV_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt_flags(evt_flags), .rd_addr(rd_addr), .rd_data(rd_data),
    .flags_q(sticky_flags), .ctrl_q(ctrl_bits), .cfg_flat(cfg_regs)
  );
endmodule

// File: rtl/spi_stat_regs_chk.sv
module spi_stat_regs_chk #(
  parameter int CFG_BITS = 96
) (
  input logic                clk,
  input logic                rst_n,
  input logic                evt_dig,
  input logic                evt_band,
  input logic [2:0]          flags,
  input logic [4:0]          ctrl,
  input logic [CFG_BITS-1:0] cfg,
  input logic                frame_end,
  input logic                frame_ok,
  input logic                wr_en,
  input logic [6:0]          wr_addr,
  input logic [23:0]         wr_data,
  input logic                cs_fall,
  input logic [5:0]          edge_cnt
);
  // R5
  dig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dig |=> flags[0]);

  // R6
  band_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_band |=> flags[1]);

  // R2
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_ok) |=> flags[2]);

  // R2
  bad_frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_ok) |=> ($stable(cfg) && $stable(ctrl)));

  // R1
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(wr_en && wr_addr == 7'd0 && wr_data[0])) |=> flags[0]);

  // R2
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cnt == 6'h3F && !cs_fall) |=> edge_cnt == 6'h3F);
endmodule

bind spi_stat_regs spi_stat_regs_chk #(.CFG_BITS(NUM_CFG*24)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .evt_dig(evt_dig_unlock), .evt_band(evt_band_sel),
  .flags(sticky_flags), .ctrl(ctrl_bits), .cfg(cfg_regs),
  .frame_end(frame_end), .frame_ok(frame_ok),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cs_fall(s_fall[2]), .edge_cnt(edge_cnt)
);

// File: tb/spi_stat_regs_test.sv
module spi_stat_regs_test;
  localparam int HALF = 6;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic evt_dig = 1'b0, evt_band = 1'b0;
  logic [2:0]  flags;
  logic [4:0]  ctrl;
  logic [95:0] cfg;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [23:0] exp_q[$];
  string       tag_q[$];
  logic [23:0] act_q[$];

  always #4 clk = ~clk;

  spi_stat_regs uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .evt_dig_unlock(evt_dig),
    .evt_band_sel(evt_band), .sticky_flags(flags), .ctrl_bits(ctrl),
    .cfg_regs(cfg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drives one frame of nclk clocks; returns data-phase bits seen on MISO
  task automatic frame(input logic rd, input logic [6:0] addr, input logic [23:0] data,
                       input int nclk, output logic [23:0] got);
    logic [31:0] word;
    word = {rd, addr, data};
    got = '0;
    @(negedge clk); cs_n = 1'b0;
    idle(HALF);
    for (int i = 0; i < nclk; i++) begin
      mosi = (i < 32) ? word[31-i] : 1'b0;
      idle(HALF);
      if (i >= 8 && i < 32) got[31-i] = miso;
      sclk = 1'b1;
      idle(HALF);
      sclk = 1'b0;
    end
    idle(HALF);
    cs_n = 1'b1;
    idle(12);
  endtask

  task automatic wr(input logic [6:0] addr, input logic [23:0] data, input int nclk);
    logic [23:0] dummy;
    frame(1'b0, addr, data, nclk, dummy);
  endtask

  task automatic rd_expect(input logic [6:0] addr, input logic [23:0] exp, input string tag);
    logic [23:0] got;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    frame(1'b1, addr, 24'h0, 32, got);
    act_q.push_back(got);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0)
        chk(tag_q.pop_front(), {8'h0, act_q.pop_front()}, {8'h0, exp_q.pop_front()});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [23:0] dummy;
    idle(5);
    rst_n = 1'b1;
    idle(5);
    // R11 reset state
    chk("R11 flags", {29'h0, flags}, 32'h0);
    chk("R11 ctrl", {27'h0, ctrl}, 32'h0);
    chk("R11 cfg", cfg[31:0], 32'h0);
    rd_expect(7'd0, 24'h025A00, "R11/R9 status read after reset");

    // R1 / R3 good writes and reads
    wr(7'd1, 24'hABCDEF, 32);
    chk("R1 cfg1", {8'h0, cfg[23:0]}, {8'h0, 24'hABCDEF});
    wr(7'd4, 24'h123456, 32);
    chk("R1 cfg4", {8'h0, cfg[95:72]}, {8'h0, 24'h123456});
    rd_expect(7'd1, 24'hABCDEF, "R3 read cfg1");
    rd_expect(7'd4, 24'h123456, "R3 read cfg4");
    chk("R3 no err after reads", {29'h0, flags}, 32'h0);

    // R2 short write frame
    wr(7'd1, 24'h111111, 31);
    chk("R2 short no write", {8'h0, cfg[23:0]}, {8'h0, 24'hABCDEF});
    chk("R2 short sets err", {31'h0, flags[2]}, 32'h1);
    wr(7'd0, 24'h000004, 32);
    chk("R7 err cleared", {29'h0, flags}, 32'h0);

    // R2 long write frame, saturation range
    wr(7'd2, 24'h777777, 70);
    chk("R2 long no write", {8'h0, cfg[47:24]}, 32'h0);
    chk("R2 long sets err", {31'h0, flags[2]}, 32'h1);
    wr(7'd0, 24'h000004, 32);

    // R4 short read frame
    frame(1'b1, 7'd1, 24'h0, 30, dummy);
    chk("R4 bad read sets err", {31'h0, flags[2]}, 32'h1);

    // R10 control bits plus clear in one write
    wr(7'd0, {16'h0, 5'b10101, 3'b100}, 32);
    chk("R10 ctrl written", {27'h0, ctrl}, 32'h15);
    chk("R7 err cleared with ctrl", {29'h0, flags}, 32'h0);
    rd_expect(7'd0, {16'h025A, 5'b10101, 3'b000}, "R10 status readback");

    // R5 / R6 events
    idle(3); evt_dig = 1'b1; idle(1); evt_dig = 1'b0; idle(20);
    chk("R5 dig flag sticky", {29'h0, flags}, 32'h1);
    evt_band = 1'b1; idle(1); evt_band = 1'b0; idle(20);
    chk("R6 band flag sticky", {29'h0, flags}, 32'h3);

    // R7 clear band only; write 0 to dig bit leaves it
    wr(7'd0, {16'h0, 5'b10101, 3'b010}, 32);
    chk("R7 selective clear", {29'h0, flags}, 32'h1);

    // R8 event on the commit cycle of the clearing write
    @(negedge clk); cs_n = 1'b0;
    idle(HALF);
    begin
      logic [31:0] w;
      w = {1'b0, 7'd0, 16'h0, 5'b10101, 3'b001};
      for (int i = 0; i < 32; i++) begin
        mosi = w[31-i];
        idle(HALF); sclk = 1'b1; idle(HALF); sclk = 1'b0;
      end
    end
    idle(HALF);
    cs_n = 1'b1;
    idle(2);
    evt_dig = 1'b1;
    idle(1);
    evt_dig = 1'b0;
    idle(12);
    chk("R8 event beats clear", {29'h0, flags}, 32'h1);
    wr(7'd0, {16'h0, 5'b10101, 3'b001}, 32);
    chk("R7 dig cleared", {29'h0, flags}, 32'h0);

    // R9 id fields read-only
    wr(7'd0, 24'hFFFF00, 32);
    rd_expect(7'd0, 24'h025A00, "R9 ids unchanged");

    // R12 unmapped address
    wr(7'd64, 24'hDEAD01, 32);
    chk("R12 cfg untouched", cfg[31:0], {8'h0, 24'hABCDEF});
    chk("R12 cfg4 untouched", {8'h0, cfg[95:72]}, {8'h0, 24'h123456});
    rd_expect(7'd64, 24'h000000, "R12 unmapped reads zero");

    idle(10);
    finish_run();
  end
endmodule